// File: doc/BRIEF.md
# Bus Handshake Monitor

This block watches, without driving anything, the five active-low control lines of a shared parallel bus that moves data in bursts of data phases. It samples the lines on every rising clock edge. From those samples it works out whether a burst is open and on which clocks a data word actually moves. It also finds the clock on which each data phase ends and marks the final phase of a burst.

The monitor also enforces the commitment rules of the handshake. Once the initiator has said it is ready, it must hold its ready and burst lines. Once the responder has said ready or has asked to stop, it must hold its ready, stop and claim lines. Both holds last until the phase ends. A change inside that window is reported as a one-clock pulse and as a flag that stays set until reset. Before either side commits, both sides may insert wait states freely. A saturating counter tallies the words moved.

All per-sample outputs describe the bus values captured at the most recent rising edge. The sticky flags and the counter take that sample into account one edge later.

Top module: `bus_handshake_monitor`

## Requirements
- R1: `xfer` is 1 for a sample where a burst is open and both `mrdy_n` and `srdy_n` are 0, and 0 otherwise.
- R2: `phase_done` is 1 for a sample where a burst is open, `mrdy_n` is 0, and at least one of `srdy_n` or `halt_n` is 0.
- R3: `last_phase` is 1 for a sample where a burst is open, `burst_n` is 1 and `mrdy_n` is 0.
- R4: Once a sample inside a burst has `mrdy_n` = 0 without ending the phase, any later sample before the phase ends whose `burst_n` or `mrdy_n` differs from the sample before it raises `mst_viol_pulse` for that sample. The sample that ends the phase is included in this check.
- R5: Once a sample inside a burst has `srdy_n` = 0 or `halt_n` = 0 without ending the phase, any later sample up to and including the one that ends the phase raises `tgt_viol_pulse` if `claim_n`, `srdy_n` or `halt_n` differs from the sample before it.
- R6: While neither side has committed, changes on any line (for example `claim_n` toggling while both ready lines are 1) raise no violation pulse.
- R7: `mst_viol` and `tgt_viol` go to 1 on the edge after their pulse and stay 1 until reset.
- R8: `xfer_count` rises by one on the edge after each `xfer` sample and holds at its all-ones maximum instead of wrapping.
- R9: `txn_active` is 1 for a sample where `burst_n` is 0, or where a burst was already open. An open burst closes after a sample with both `burst_n` and `mrdy_n` at 1.
- R10: A synchronous reset (`rst` = 1) treats the bus as idle and clears the commitments, the flags and the counter. Afterwards every output reads 0.
- R11: The sample that ends a phase releases both commitments, so line changes on the next sample raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst | input | 1 | Synchronous reset, active high |
| burst_n | input | 1 | Initiator burst-in-progress, active low; 1 during the final phase |
| mrdy_n | input | 1 | Initiator ready, active low |
| srdy_n | input | 1 | Responder ready, active low |
| halt_n | input | 1 | Responder stop request, active low |
| claim_n | input | 1 | Responder has claimed the burst, active low |
| txn_active | output | 1 | Burst open for the current sample |
| xfer | output | 1 | A data word moves on the current sample |
| phase_done | output | 1 | The current data phase ends on this sample |
| last_phase | output | 1 | The current sample belongs to the final phase |
| mst_viol_pulse | output | 1 | Initiator changed a committed line on this sample |
| tgt_viol_pulse | output | 1 | Responder changed a committed line on this sample |
| mst_viol | output | 1 | Sticky initiator violation flag |
| tgt_viol | output | 1 | Sticky responder violation flag |
| xfer_count | output | CNT_W | Saturating count of transferred words |

## Verification
A committed initiator can drop its burst line on the same sample that the responder asks to stop. That one sample both ends the phase and breaks the hold rule, so `phase_done`, `last_phase` and `mst_viol_pulse` must all be 1 together, and the release must not hide the violation. A second collision comes from a long burst of back-to-back transfers: it drives the counter into saturation while `xfer` stays high. A scoreboard model predicts every per-sample output and the delayed flag and count values on each cycle and compares them against the design.

// File: rtl/bhm_pkg.sv
package bhm_pkg;

   typedef struct packed {
      logic burst_n;
      logic mrdy_n;
      logic srdy_n;
      logic halt_n;
      logic claim_n;
   } bus_ctl_t;

   localparam int unsigned CTL_W = $bits(bus_ctl_t);
   localparam bus_ctl_t    BUS_IDLE = '1;

   localparam int unsigned MST_WATCH_W = 2;
   localparam int unsigned TGT_WATCH_W = 3;

endpackage

// File: rtl/bhm_sampler.sv
module bhm_sampler
   import bhm_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  bus_ctl_t bus_i,
   output bus_ctl_t cur_o,
   output bus_ctl_t prev_o
);

   bus_ctl_t cur_q;
   bus_ctl_t prev_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cur_q  <= BUS_IDLE;
         prev_q <= BUS_IDLE;
      end else begin
         prev_q <= cur_q;
         cur_q  <= bus_i;
      end
   end

   assign cur_o  = cur_q;
   assign prev_o = prev_q;

endmodule

// File: rtl/bhm_phase_decode.sv
module bhm_phase_decode (
   input  logic clk,
   input  logic rst,
   input  logic burst_n_i,
   input  logic mrdy_n_i,
   input  logic srdy_n_i,
   input  logic halt_n_i,
   output logic in_txn_o,
   output logic xfer_o,
   output logic done_o,
   output logic last_o,
   output logic mst_arm_o,
   output logic tgt_arm_o
);

   logic open_q;
   logic open_d;

   always_comb begin
      in_txn_o  = open_q | ~burst_n_i;
      xfer_o    = in_txn_o & ~mrdy_n_i & ~srdy_n_i;
      done_o    = in_txn_o & ~mrdy_n_i & (~srdy_n_i | ~halt_n_i);
      last_o    = in_txn_o & burst_n_i & ~mrdy_n_i;
      mst_arm_o = in_txn_o & ~mrdy_n_i;
      tgt_arm_o = in_txn_o & (~srdy_n_i | ~halt_n_i);
      if (open_q) open_d = ~(burst_n_i & mrdy_n_i);
      else        open_d = ~burst_n_i;
   end

   always_ff @(posedge clk) begin
      if (rst) open_q <= 1'b0;
      else     open_q <= open_d;
   end

   // R9: a burst may only close after a sample with both lines idle
   a_r9_close_needs_idle: assert property (@(posedge clk) disable iff (rst)
      (open_q && burst_n_i && mrdy_n_i) |=> !open_q);

endmodule

// File: rtl/bhm_commit_tracker.sv
module bhm_commit_tracker #(
   parameter int unsigned W = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         arm_i,
   input  logic         release_i,
   input  logic [W-1:0] cur_i,
   input  logic [W-1:0] prev_i,
   output logic         held_o,
   output logic         pulse_o,
   output logic         flag_o
);

   if (W < 1) begin : g_bad_w
      $error("bhm_commit_tracker: W must be at least 1");
   end

   logic held_q;
   logic flag_q;

   assign pulse_o = held_q & (cur_i != prev_i);

   always_ff @(posedge clk) begin
      if (rst) begin
         held_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         held_q <= release_i ? 1'b0 : (held_q | arm_i);
         flag_q <= flag_q | pulse_o;
      end
   end

   assign held_o = held_q;
   assign flag_o = flag_q;

   // R7: once set, the flag never clears without reset
   a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
      flag_q |=> flag_q);

endmodule

// File: rtl/bhm_xfer_counter.sv
module bhm_xfer_counter #(
   parameter int unsigned CNT_W    = 16,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             inc_i,
   output logic [CNT_W-1:0] count_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_step;

   if (SATURATE) begin : g_sat
      assign cnt_step = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

      // R8: the maximum holds under further increments
      a_r8_sat_hold: assert property (@(posedge clk) disable iff (rst)
         (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
   end else begin : g_wrap
      assign cnt_step = cnt_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst)        cnt_q <= '0;
      else if (inc_i) cnt_q <= cnt_step;
   end

   assign count_o = cnt_q;

endmodule

// File: rtl/bus_handshake_monitor.sv
module bus_handshake_monitor
   import bhm_pkg::*;
#(
   parameter int unsigned CNT_W    = 16,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             burst_n,
   input  logic             mrdy_n,
   input  logic             srdy_n,
   input  logic             halt_n,
   input  logic             claim_n,
   output logic             txn_active,
   output logic             xfer,
   output logic             phase_done,
   output logic             last_phase,
   output logic             mst_viol_pulse,
   output logic             tgt_viol_pulse,
   output logic             mst_viol,
   output logic             tgt_viol,
   output logic [CNT_W-1:0] xfer_count
);

   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
      $error("bus_handshake_monitor: CNT_W must lie in 1..32");
   end

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   bus_ctl_t bus_in;
   bus_ctl_t s_cur;
   bus_ctl_t s_prev;

   assign bus_in = '{burst_n: burst_n, mrdy_n: mrdy_n, srdy_n: srdy_n,
                     halt_n: halt_n, claim_n: claim_n};

   bhm_sampler u_sampler (
      .clk    (clk),
      .rst    (rst),
      .bus_i  (bus_in),
      .cur_o  (s_cur),
      .prev_o (s_prev)
   );

   logic mst_arm;
   logic tgt_arm;

   bhm_phase_decode u_decode (
      .clk       (clk),
      .rst       (rst),
      .burst_n_i (s_cur.burst_n),
      .mrdy_n_i  (s_cur.mrdy_n),
      .srdy_n_i  (s_cur.srdy_n),
      .halt_n_i  (s_cur.halt_n),
      .in_txn_o  (txn_active),
      .xfer_o    (xfer),
      .done_o    (phase_done),
      .last_o    (last_phase),
      .mst_arm_o (mst_arm),
      .tgt_arm_o (tgt_arm)
   );

   logic [MST_WATCH_W-1:0] mst_cur, mst_prev;
   logic [TGT_WATCH_W-1:0] tgt_cur, tgt_prev;
   logic                   mst_held, tgt_held;

   assign mst_cur  = {s_cur.burst_n,  s_cur.mrdy_n};
   assign mst_prev = {s_prev.burst_n, s_prev.mrdy_n};
   assign tgt_cur  = {s_cur.claim_n,  s_cur.srdy_n,  s_cur.halt_n};
   assign tgt_prev = {s_prev.claim_n, s_prev.srdy_n, s_prev.halt_n};

   bhm_commit_tracker #(.W(MST_WATCH_W)) u_mst_commit (
      .clk       (clk),
      .rst       (rst),
      .arm_i     (mst_arm),
      .release_i (phase_done),
      .cur_i     (mst_cur),
      .prev_i    (mst_prev),
      .held_o    (mst_held),
      .pulse_o   (mst_viol_pulse),
      .flag_o    (mst_viol)
   );

   bhm_commit_tracker #(.W(TGT_WATCH_W)) u_tgt_commit (
      .clk       (clk),
      .rst       (rst),
      .arm_i     (tgt_arm),
      .release_i (phase_done),
      .cur_i     (tgt_cur),
      .prev_i    (tgt_prev),
      .held_o    (tgt_held),
      .pulse_o   (tgt_viol_pulse),
      .flag_o    (tgt_viol)
   );

   bhm_xfer_counter #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_counter (
      .clk     (clk),
      .rst     (rst),
      .inc_i   (xfer),
      .count_o (xfer_count)
   );

   // R8: each transfer below the maximum advances the count by one
   a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
      (xfer && xfer_count != CNT_MAX) |=> (xfer_count == CNT_W'($past(xfer_count) + 1'b1)));

   // R8: no transfer, no count change
   a_r8_count_idle: assert property (@(posedge clk) disable iff (rst)
      !xfer |=> $stable(xfer_count));

   // R4: an initiator pulse is latched into its flag
   a_r4_mst_flag_set: assert property (@(posedge clk) disable iff (rst)
      mst_viol_pulse |=> mst_viol);

   // R5: a responder pulse is latched into its flag
   a_r5_tgt_flag_set: assert property (@(posedge clk) disable iff (rst)
      tgt_viol_pulse |=> tgt_viol);

   // R11: phase completion drops both commitments
   a_r11_release: assert property (@(posedge clk) disable iff (rst)
      phase_done |=> (!mst_held && !tgt_held));

   // R1: a word can only move on a sample that also ends the phase
   a_r1_xfer_ends_phase: assert property (@(posedge clk) disable iff (rst)
      xfer |-> phase_done);

endmodule

// File: tb/bus_handshake_monitor_test.sv
`timescale 1ns/1ps
module bus_handshake_monitor_test;

   localparam int CW   = 6;
   localparam int CMAX = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic b_n = 1'b1, m_n = 1'b1, s_n = 1'b1, h_n = 1'b1, c_n = 1'b1;
   logic txn, xf, dn, lst, mp, tp, mf, tf;
   logic [CW-1:0] cnt;

   always #2.5 clk = ~clk;

   bus_handshake_monitor #(.CNT_W(CW), .SATURATE(1'b1)) uut (
      .clk(clk), .rst(rst),
      .burst_n(b_n), .mrdy_n(m_n), .srdy_n(s_n), .halt_n(h_n), .claim_n(c_n),
      .txn_active(txn), .xfer(xf), .phase_done(dn), .last_phase(lst),
      .mst_viol_pulse(mp), .tgt_viol_pulse(tp), .mst_viol(mf), .tgt_viol(tf),
      .xfer_count(cnt)
   );

   typedef struct {
      bit txn, xf, dn, lst, mp, tp, mf, tf;
      int cnt;
      int due;
   } exp_t;

   exp_t q[$];
   int   pcount = 0;
   int   ncmp = 0;
   int   nbad = 0;
   bit   finished = 1'b0;

   // reference model state
   bit   r_open, r_mheld, r_theld, r_mflag, r_tflag;
   bit   p_b, p_m, p_s, p_h, p_c;
   int   r_cnt;

   always @(posedge clk) pcount++;

   task automatic chk(input string tag, input int act, input int exp);
      ncmp++;
      if (act != exp) begin
         nbad++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      r_open = 0; r_mheld = 0; r_theld = 0; r_mflag = 0; r_tflag = 0;
      p_b = 1; p_m = 1; p_s = 1; p_h = 1; p_c = 1;
      r_cnt = 0;
   endtask

   // driver: applies one vector and queues the outputs it must produce
   task automatic drive(input bit b, input bit m, input bit s, input bit h, input bit c);
      exp_t e;
      @(negedge clk);
      b_n = b; m_n = m; s_n = s; h_n = h; c_n = c;
      e.txn = r_open || !b;
      e.xf  = e.txn && !m && !s;
      e.dn  = e.txn && !m && (!s || !h);
      e.lst = e.txn && b && !m;
      e.mp  = r_mheld && ((b != p_b) || (m != p_m));
      e.tp  = r_theld && ((c != p_c) || (s != p_s) || (h != p_h));
      e.mf  = r_mflag;
      e.tf  = r_tflag;
      e.cnt = r_cnt;
      e.due = pcount + 1;
      q.push_back(e);
      r_mflag = r_mflag || e.mp;
      r_tflag = r_tflag || e.tp;
      if (e.xf && r_cnt < CMAX) r_cnt++;
      r_mheld = e.dn ? 1'b0 : (r_mheld || (e.txn && !m));
      r_theld = e.dn ? 1'b0 : (r_theld || (e.txn && (!s || !h)));
      r_open  = r_open ? !(b && m) : !b;
      p_b = b; p_m = m; p_s = s; p_h = h; p_c = c;
   endtask

   // monitor: pops items whose sample edge has passed and compares
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].due <= pcount) begin
         exp_t e;
         e = q.pop_front();
         chk("R9 txn_active",     txn, e.txn);
         chk("R1 xfer",           xf,  e.xf);
         chk("R2 phase_done",     dn,  e.dn);
         chk("R3 last_phase",     lst, e.lst);
         chk("R4/R6/R11 mst_viol_pulse", mp, e.mp);
         chk("R5/R6/R11 tgt_viol_pulse", tp, e.tp);
         chk("R7 mst_viol",       mf,  e.mf);
         chk("R7 tgt_viol",       tf,  e.tf);
         chk("R8 xfer_count",     int'(cnt), e.cnt);
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      b_n = 1; m_n = 1; s_n = 1; h_n = 1; c_n = 1;
      q.delete();
      model_reset();
      repeat (2) @(negedge clk);
      rst = 1'b0;
      // R10: everything reads zero straight after reset
      chk("R10 txn_active", txn, 0);
      chk("R10 xfer",       xf,  0);
      chk("R10 phase_done", dn,  0);
      chk("R10 last_phase", lst, 0);
      chk("R10 mst_viol",   mf,  0);
      chk("R10 tgt_viol",   tf,  0);
      chk("R10 xfer_count", int'(cnt), 0);
   endtask

   task automatic drain();
      repeat (3) drive(1, 1, 1, 1, 1);
      @(negedge clk);
   endtask

   initial begin : wdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         nbad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
         $finish;
      end
   end

   initial begin
      model_reset();
      do_reset();
      drain();

      // R1 R2 R3 R9: clean burst with an initiator wait then three words
      drive(0, 1, 1, 1, 1);
      drive(0, 0, 1, 1, 0);
      drive(0, 0, 0, 1, 0);
      drive(0, 0, 0, 1, 0);
      drive(1, 0, 0, 1, 0);
      drain();

      // R6 R11: claim toggles before any commitment, then normal ending
      drive(0, 1, 1, 1, 1);
      drive(0, 1, 1, 1, 0);
      drive(0, 1, 1, 1, 1);
      drive(0, 1, 1, 1, 0);
      drive(0, 1, 0, 1, 0);
      drive(0, 0, 0, 1, 0);
      drive(1, 0, 0, 1, 0);
      drain();

      // R4: initiator withdraws its ready after committing
      drive(0, 1, 1, 1, 1);
      drive(0, 0, 1, 1, 0);
      drive(0, 1, 1, 1, 0);
      drive(0, 0, 0, 1, 0);
      drive(1, 0, 0, 1, 0);
      drain();

      // R5: responder withdraws its ready after committing
      drive(0, 1, 1, 1, 1);
      drive(0, 1, 0, 1, 0);
      drive(0, 1, 1, 1, 0);
      drive(0, 0, 0, 1, 0);
      drive(1, 0, 0, 1, 0);
      drain();

      // R2 R3 R4: burst line flips on the same sample a stop ends the phase
      drive(0, 1, 1, 1, 1);
      drive(0, 0, 1, 1, 0);
      drive(1, 0, 1, 0, 0);
      drain();

      // R8: long back-to-back burst drives the counter into saturation
      drive(0, 1, 1, 1, 1);
      for (int i = 0; i < 70; i++) drive(0, 0, 0, 1, 0);
      drive(1, 0, 0, 1, 0);
      drain();

      // R10 R7: reset clears sticky flags and count, then one clean burst
      do_reset();
      drive(0, 1, 1, 1, 1);
      drive(0, 0, 0, 1, 0);
      drive(1, 0, 0, 1, 0);
      drain();

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
   end

endmodule